// File: doc/BRIEF.md
# Configurable Cascadable Interrupt Controller

The block gathers up to 32 interrupt sources into one request line for a processor or for another controller of the same kind. Each source is given a sensing style by parameter. An edge source latches a sticky status bit on its active transition, which is rising or falling. A level source shows its active state, high or low, in status for as long as it lasts. Software reads and controls the block through eight 32-bit registers on a simple single-cycle register bus.

The pending set is the status bits that are also enabled. A master enable bit gates the request output. A parameter makes that output either a level that stays high while anything is pending, or a one-cycle pulse each time the pending set goes from empty to non-empty. The pulse form can drive an edge-sensed input of an upstream controller, so instances can be cascaded. A vector register gives software the index of the lowest-numbered pending source.

Register word index (on `bus_addr`): 0 status (read only), 1 pending (read only), 2 enable (read/write), 3 acknowledge (write only, reads 0), 4 enable-set (write only, reads 0), 5 enable-clear (write only, reads 0), 6 vector (read only), 7 master (bit 0, read/write). Writes take effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `intr_hub`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), status, enable and master read 0, vector reads 0xFFFFFFFF and `irq_o` is 0.
- R2: An edge source sets its status bit at the first clock edge that samples its active transition. With polarity bit 1 the active transition is 0 to 1; with polarity bit 0 it is 1 to 0. The bit stays set after the source goes back to its idle level. A source that is already active when reset is released does not count as a transition.
- R3: Writing a 1 to bit i of the acknowledge register (index 3) clears edge status bit i at that clock edge. Acknowledge bits written as 0 leave their status bits untouched. Acknowledging a level source has no effect.
- R4: A level source's status bit is 1 from the clock edge after the source reaches its active level (high for polarity 1, low for polarity 0), and goes back to 0 one clock edge after the source leaves it.
- R5: Pending (index 1) reads status AND enable. Enable (index 2) can be written whole. A 1 in enable-set (index 4) sets that enable bit, a 1 in enable-clear (index 5) clears it, and a 0 in either leaves that bit as it was.
- R6: Vector (index 6) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when nothing is pending.
- R7: In level mode `irq_o` is 1 one clock edge after pending is non-zero while master bit 0 (index 7) is 1. When master is 0, `irq_o` is 0 and status is left as it is.
- R8: In pulse mode `irq_o` is high for exactly one cycle per empty-to-non-empty change of the master-gated pending set. It does not pulse again while that set stays non-empty.
- R9: Writes to status, pending and vector change nothing. Register bits at or above the number of sources read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt sources |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Request output (level or pulse) |

## Verification
The hardest case to reach is the pulse output's refusal to fire a second time. The bench must make the pending set non-empty, add a second source while the first is still pending, and only then empty the set and fill it again. The stimulus does this with a level-mode and a pulse-mode instance on the same bus and sources, and counts pulses at falling clock edges. That count must be exactly two, and no pulse may last more than one cycle. Acknowledging a level source, and writing to the read-only registers, are checked by reading status back at once.

// File: rtl/intr_hub_pkg.sv
// Package: register indices and the width constant shared by the
// interrupt controller modules. Assumes a 32-bit register bus.
package intr_hub_pkg;
    localparam int unsigned BUS_W = 32;

    typedef enum logic [2:0] {
        RIDX_STATUS = 3'd0,
        RIDX_PEND   = 3'd1,
        RIDX_ENABLE = 3'd2,
        RIDX_ACK    = 3'd3,
        RIDX_SETEN  = 3'd4,
        RIDX_CLREN  = 3'd5,
        RIDX_VECTOR = 3'd6,
        RIDX_MASTER = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/intr_sense.sv
// Module: intr_sense
// Turns each raw source into one status bit. The sensing style is picked
// per bit by parameter: sticky edge capture or a registered level follower.
// Assumes the sources are already synchronous to clk.
module intr_sense #(
    parameter int unsigned N_SRC     = 8,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0,
    parameter logic [N_SRC-1:0] POL_MASK  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] ack_i,
    output logic [N_SRC-1:0] status_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic act;
        // Normalise polarity so that 1 always means "asserted".
        assign act = POL_MASK[i] ? src_i[i] : ~src_i[i];

        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            // Track the previous level; reset assumes active so no false edge.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b1;
                else        prev_q <= act;
            end
            // Sticky capture: a new edge wins over a same-cycle acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n)               status_o[i] <= 1'b0;
                else if (act && !prev_q)  status_o[i] <= 1'b1;
                else if (ack_i[i])        status_o[i] <= 1'b0;
            end
        end else begin : g_level
            // Level follower: acknowledge is ignored.
            always_ff @(posedge clk) begin
                if (!rst_n) status_o[i] <= 1'b0;
                else        status_o[i] <= act;
            end
        end
    end
endmodule

// File: rtl/intr_regs.sv
// Module: intr_regs
// Register file: holds enable and master, decodes the one-shot
// acknowledge/set/clear writes, and muxes the read data.
// Assumes single-cycle writes and combinational reads.
module intr_regs
    import intr_hub_pkg::*;
#(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [2:0]       addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [N_SRC-1:0] status_i,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [BUS_W-1:0] vector_i,
    output logic [N_SRC-1:0] enable_o,
    output logic             master_o,
    output logic [N_SRC-1:0] ack_o,
    output logic [BUS_W-1:0] rdata_o
);
    reg_idx_e           idx;
    logic [N_SRC-1:0]   wbits;

    assign idx   = reg_idx_e'(addr_i);
    assign wbits = wdata_i[N_SRC-1:0];

    // Acknowledge is a write-only strobe into the sensing stage.
    assign ack_o = (we_i && idx == RIDX_ACK) ? wbits : '0;

    // Enable register: whole write, bitwise set, bitwise clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= '0;
        end else if (we_i) begin
            case (idx)
                RIDX_ENABLE: enable_o <= wbits;
                RIDX_SETEN:  enable_o <= enable_o | wbits;
                RIDX_CLREN:  enable_o <= enable_o & ~wbits;
                default:     enable_o <= enable_o;
            endcase
        end
    end

    // Master enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         master_o <= 1'b0;
        else if (we_i && idx == RIDX_MASTER) master_o <= wdata_i[0];
    end

    // Read multiplexer; write-only locations read as zero.
    always_comb begin
        rdata_o = '0;
        case (idx)
            RIDX_STATUS: rdata_o[N_SRC-1:0] = status_i;
            RIDX_PEND:   rdata_o[N_SRC-1:0] = pend_i;
            RIDX_ENABLE: rdata_o[N_SRC-1:0] = enable_o;
            RIDX_VECTOR: rdata_o            = vector_i;
            RIDX_MASTER: rdata_o[0]         = master_o;
            default:     rdata_o            = '0;
        endcase
    end
endmodule

// File: rtl/intr_vec.sv
// Module: intr_vec
// Finds the lowest-numbered set bit of the pending vector.
// Returns all ones when none is set. Purely combinational.
module intr_vec
    import intr_hub_pkg::*;
#(
    parameter int unsigned N_SRC = 8
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic [BUS_W-1:0] vector_o
);
    // Scan from the top down so the lowest index is written last.
    always_comb begin
        vector_o = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) vector_o = BUS_W'(i);
        end
    end
endmodule

// File: rtl/intr_out.sv
// Module: intr_out
// Output stage: a registered level request, or a one-cycle pulse on
// each rise of the gated request, chosen by parameter.
module intr_out #(
    parameter bit OUT_PULSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    input  logic master_i,
    output logic irq_o
);
    logic req;
    assign req = any_i & master_i;

    if (OUT_PULSE) begin : g_pulse
        logic req_q;
        // Remember last cycle's gated request for rise detection.
        always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= req;
        end
        // Fire one cycle on each rise.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= req & ~req_q;
        end
    end else begin : g_level
        // Follow the gated request one cycle later.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= req;
        end
    end
endmodule

// File: rtl/intr_hub.sv
// Module: intr_hub (top)
// Cascadable interrupt controller: per-source sensing, enable masking,
// master gating, lowest-index vector, and a level or pulse request.
// Assumes N_SRC between 1 and 32, and sources synchronous to clk.
module intr_hub
    import intr_hub_pkg::*;
#(
    parameter int unsigned      N_SRC     = 8,
    parameter logic [N_SRC-1:0] EDGE_MASK = 8'h0F,
    parameter logic [N_SRC-1:0] POL_MASK  = 8'h35,
    parameter bit               OUT_PULSE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o
);
    logic [N_SRC-1:0] status_w;
    logic [N_SRC-1:0] enable_w;
    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] ack_w;
    logic [BUS_W-1:0] vector_w;
    logic             master_w;

    // Pending is the enabled part of status.
    assign pend_w = status_w & enable_w;

    intr_sense #(
        .N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK), .POL_MASK(POL_MASK)
    ) u_sense (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .ack_i(ack_w), .status_o(status_w)
    );

    intr_regs #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .status_i(status_w), .pend_i(pend_w),
        .vector_i(vector_w), .enable_o(enable_w), .master_o(master_w),
        .ack_o(ack_w), .rdata_o(bus_rdata)
    );

    intr_vec #(.N_SRC(N_SRC)) u_vec (
        .pend_i(pend_w), .vector_o(vector_w)
    );

    intr_out #(.OUT_PULSE(OUT_PULSE)) u_out (
        .clk(clk), .rst_n(rst_n), .any_i(|pend_w),
        .master_i(master_w), .irq_o(irq_o)
    );
endmodule

// File: rtl/intr_hub_chk.sv
// Module: intr_hub_chk
// Property checker bound into every intr_hub instance.
module intr_hub_chk #(
    parameter int unsigned      N_SRC     = 8,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0,
    parameter bit               OUT_PULSE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             master_w,
    input logic [N_SRC-1:0] status_w,
    input logic [N_SRC-1:0] pend_w,
    input logic [N_SRC-1:0] ack_w,
    input logic [31:0]      vector_w
);
    logic [31:0] pend32;
    assign pend32 = 32'(pend_w);

    // R1: request is low in the cycle after a reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    // R3: an edge status bit only drops when it was acknowledged.
    assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_w) & EDGE_MASK & ~$past(ack_w)) & ~status_w) == '0);

    // R5: pending never holds a bit that status lacks.
    assert_pend_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w & ~status_w) == '0);

    // R6: a valid vector points at a pending bit.
    assert_vector_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vector_w != 32'hFFFF_FFFF) |-> pend32[vector_w[4:0]]);

    // R6: nothing pending means the empty code.
    assert_vector_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w == '0) |-> (vector_w == 32'hFFFF_FFFF));

    // R7: a request needs master set in the cycle before.
    assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(master_w));

    // R8: in pulse mode the request never lasts two cycles.
    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_PULSE && irq_o) |=> !irq_o);
endmodule

bind intr_hub intr_hub_chk #(
    .N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK), .OUT_PULSE(OUT_PULSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .master_w(master_w),
    .status_w(status_w), .pend_w(pend_w), .ack_w(ack_w),
    .vector_w(vector_w)
);

// File: tb/test_intr_hub.sv
// Directed bench: a level-mode and a pulse-mode instance share the bus
// and sources. Sources: bits 0,2 rising edge; 1,3 falling edge;
// 4,5 level high; 6,7 level low. Idle source pattern 0xCA.
module test_intr_hub;
    localparam logic [7:0] IDLE = 8'hCA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = IDLE;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_l, rd_p;
    logic        irq_l, irq_p;

    int total = 0;
    int bad = 0;
    int pulse_cnt = 0;
    int run_len = 0;
    int max_run = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intr_hub i_intr_hub (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_l), .irq_o(irq_l)
    );

    intr_hub #(.OUT_PULSE(1'b1)) i_intr_hub_pulse (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_p), .irq_o(irq_p)
    );

    // Pulse monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (irq_p) begin
            if (run_len == 0) pulse_cnt++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_l;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 status", v, 32'h0);
        rd(3'd2, v); check("R1 enable", v, 32'h0);
        rd(3'd7, v); check("R1 master", v, 32'h0);
        rd(3'd6, v); check("R1 vector", v, 32'hFFFF_FFFF);
        check("R1 irq", {31'd0, irq_l}, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        src[0] = 1'b1; src[1] = 1'b0;
        tick();
        src = IDLE;
        tick();
        rd(3'd0, v); check("R2 edge capture", v, 32'h03);
        tick();
        rd(3'd0, v); check("R2 sticky", v, 32'h03);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(3'd3, 32'h01);
        rd(3'd0, v); check("R3 ack one bit", v, 32'h02);
        wr(3'd3, 32'h02);
        rd(3'd0, v); check("R3 ack other", v, 32'h00);
    endtask

    task automatic t_level();
        logic [31:0] v;
        src[4] = 1'b1; src[6] = 1'b0;
        tick();
        rd(3'd0, v); check("R4 level active", v, 32'h50);
        wr(3'd3, 32'h50);
        rd(3'd0, v); check("R3 ack on level ignored", v, 32'h50);
        src = IDLE;
        tick();
        rd(3'd0, v); check("R4 level released", v, 32'h00);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(3'd2, 32'h0F);
        wr(3'd4, 32'h30);
        rd(3'd2, v); check("R5 set-enable", v, 32'h3F);
        wr(3'd5, 32'h01);
        rd(3'd2, v); check("R5 clear-enable", v, 32'h3E);
        src[0] = 1'b1; src[2] = 1'b1;
        tick();
        src = IDLE;
        tick();
        rd(3'd0, v); check("R5 status", v, 32'h05);
        rd(3'd1, v); check("R5 pending", v, 32'h04);
        rd(3'd6, v); check("R6 vector masked", v, 32'h2);
        wr(3'd2, 32'hFF);
        rd(3'd6, v); check("R6 vector lowest", v, 32'h0);
        wr(3'd3, 32'hFF);
        rd(3'd6, v); check("R6 vector empty", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_master();
        logic [31:0] v;
        src[2] = 1'b1;
        tick();
        tick();
        check("R7 masked by master", {31'd0, irq_l}, 32'h0);
        rd(3'd0, v); check("R7 status kept", v, 32'h04);
        wr(3'd7, 32'h1);
        tick();
        check("R7 irq level on", {31'd0, irq_l}, 32'h1);
        wr(3'd7, 32'h0);
        tick();
        check("R7 irq off", {31'd0, irq_l}, 32'h0);
        src = IDLE;
        wr(3'd3, 32'hFF);
    endtask

    task automatic t_pulse();
        pulse_cnt = 0;
        max_run = 0;
        wr(3'd7, 32'h1);
        src[0] = 1'b1;
        tick();
        src[0] = 1'b0;
        repeat (3) tick();
        src[2] = 1'b1;
        tick();
        src[2] = 1'b0;
        repeat (3) tick();
        check("R8 no repeat while busy", 32'(pulse_cnt), 32'd1);
        check("R7 level stays high", {31'd0, irq_l}, 32'h1);
        wr(3'd3, 32'hFF);
        repeat (2) tick();
        src[0] = 1'b1;
        tick();
        src = IDLE;
        repeat (3) tick();
        check("R8 pulse count", 32'(pulse_cnt), 32'd2);
        check("R8 pulse width", 32'(max_run), 32'd1);
        wr(3'd3, 32'hFF);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        src[1] = 1'b0;
        tick();
        src = IDLE;
        wr(3'd0, 32'hFF);
        wr(3'd1, 32'hFF);
        wr(3'd6, 32'h0);
        rd(3'd0, v); check("R9 status write ignored", v, 32'h02);
        rd(3'd6, v); check("R9 vector write ignored", v, 32'h1);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R9 upper bits zero", v, 32'hFF);
        rd(3'd3, v); check("R9 ack reads zero", v, 32'h0);
    endtask

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_edge();
        t_ack();
        t_level();
        t_enable();
        t_master();
        t_pulse();
        t_readonly();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule